// File: doc/BRIEF.md
# Channel Threshold Comparator Bank

This block watches a stream of tagged conversion results. Each result carries a 12-bit value and a 4-bit channel tag. The block compares every result against a bank of eight programmable threshold slots. Each slot holds an enable bit, the channel it watches, a comparison direction and a 12-bit limit. Comparisons are strict, so a value equal to the limit never trips a slot. When an enabled slot's channel equals the sample's tag and its comparison holds, the slot's status bit is set. That bit stays set until software writes a one to it. Several slots may watch the same channel, and all of them are judged on the same sample.

A separate window comparator watches the battery channel, which is tag 8. It has its own high and low limits. A battery sample strictly above the high limit or strictly below the low limit sets a ninth status bit. An interrupt line is raised whenever any status bit is set and unmasked.

The sample input is a valid/ready stream that never applies back-pressure: `smp_ready` is held high, and every cycle with `smp_valid` high consumes one sample. Configuration and status pins are plain registers and wires.

Top module: `chan_thresh_bank`

## Requirements
- R1: After reset, all nine status bits and `irq` are 0, every slot is disabled, and the battery limits are high = 4095 and low = 0.
- R2: A slot whose enable bit is 0 never sets its status bit, whatever the sample is.
- R3: A slot is judged only on samples whose tag equals its programmed channel. Samples with any other tag leave its status bit alone.
- R4: A slot with direction bit 1 (greater) trips when value > limit. A value equal to the limit does not trip it.
- R5: A slot with direction bit 0 (less) trips when value < limit. A value equal to the limit does not trip it.
- R6: Every slot that matches one sample sets its bit on that sample. Slot k sets status bit k, one clock after the sample is accepted.
- R7: Status bits are sticky. Writing a 1 to bit k of `sts_clr` clears status bit k on the next clock. If a new trip of bit k arrives in the same cycle, the set wins.
- R8: A sample with tag 8 sets status bit 8 when value > battery high or value < battery low. Both comparisons are strict.
- R9: `irq` equals the OR over all bits of (status AND `irq_mask`). It follows the status register and the mask with no further delay.
- R10: `smp_ready` is always 1. A cycle with `smp_valid` low changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample present |
| smp_ready | output | 1 | Always high; the block never applies back-pressure |
| smp_tag | input | 4 | Channel tag of the sample |
| smp_value | input | 12 | Conversion value |
| cfg_we | input | 1 | Write enable for one threshold slot |
| cfg_idx | input | 3 | Slot to write |
| cfg_en | input | 1 | Slot enable |
| cfg_gt | input | 1 | 1 = greater-than, 0 = less-than |
| cfg_chan | input | 4 | Channel the slot watches |
| cfg_limit | input | 12 | Slot limit |
| bat_we | input | 1 | Write enable for both battery limits |
| bat_hi | input | 12 | Battery high limit |
| bat_lo | input | 12 | Battery low limit |
| sts_clr | input | 9 | Write-one-to-clear for status bits (bit 8 = battery) |
| irq_mask | input | 9 | Interrupt enable per status bit |
| sts | output | 9 | Sticky status bits |
| irq | output | 1 | Interrupt request |

## Verification
A wrong slot register or a faulty comparator shows at `sts` one clock after the first sample that reaches the boundary of that slot's limit. The bench therefore sweeps every tag against values just below, at and just above every programmed limit. A broken sticky or clear path shows one clock after the next clear or idle cycle. Mask errors show on `irq` in the same cycle as the status they gate.

// File: rtl/thrcmp_pkg.sv
package thrcmp_pkg;
  localparam int VAL_W = 12;
  localparam int TAG_W = 4;

  typedef struct packed {
    logic             en;
    logic             gt;
    logic [TAG_W-1:0] chan;
    logic [VAL_W-1:0] limit;
  } slot_cfg_t;
endpackage

// File: rtl/thr_slot.sv
module thr_slot
  import thrcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  slot_cfg_t        cfg_i,
  input  logic             valid_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [VAL_W-1:0] value_i,
  output logic             hit_o
);
  slot_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_i) cfg_q <= cfg_i;
  end

  logic cmp_true;
  always_comb begin
    if (cfg_q.gt) cmp_true = value_i > cfg_q.limit;
    else          cmp_true = value_i < cfg_q.limit;
    hit_o = valid_i && cfg_q.en && (tag_i == cfg_q.chan) && cmp_true;
  end

  // R3
  slot_tag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (tag_i == cfg_q.chan));
  // R4
  slot_no_equal_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (value_i != cfg_q.limit));
endmodule

// File: rtl/bat_window.sv
module bat_window
  import thrcmp_pkg::*;
#(
  parameter logic [TAG_W-1:0] BAT_TAG = 4'd8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [VAL_W-1:0] hi_i,
  input  logic [VAL_W-1:0] lo_i,
  input  logic             valid_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [VAL_W-1:0] value_i,
  output logic             hit_o
);
  logic [VAL_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '1;
      lo_q <= '0;
    end else if (wr_i) begin
      hi_q <= hi_i;
      lo_q <= lo_i;
    end
  end

  always_comb
    hit_o = valid_i && (tag_i == BAT_TAG) && ((value_i > hi_q) || (value_i < lo_q));

  // R8
  bat_tag_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (tag_i == BAT_TAG && valid_i));
endmodule

// File: rtl/chan_thresh_bank.sv
module chan_thresh_bank
  import thrcmp_pkg::*;
#(
  parameter int               N_SLOT  = 8,
  parameter logic [TAG_W-1:0] BAT_TAG = 4'd8,
  localparam int              IDX_W   = $clog2(N_SLOT),
  localparam int              N_STS   = N_SLOT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [TAG_W-1:0] smp_tag,
  input  logic [VAL_W-1:0] smp_value,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_en,
  input  logic             cfg_gt,
  input  logic [TAG_W-1:0] cfg_chan,
  input  logic [VAL_W-1:0] cfg_limit,
  input  logic             bat_we,
  input  logic [VAL_W-1:0] bat_hi,
  input  logic [VAL_W-1:0] bat_lo,
  input  logic [N_STS-1:0] sts_clr,
  input  logic [N_STS-1:0] irq_mask,
  output logic [N_STS-1:0] sts,
  output logic             irq
);
  logic [N_STS-1:0] hit;
  logic             take;
  slot_cfg_t        wr_cfg;

  assign smp_ready = 1'b1;
  assign take      = smp_valid && smp_ready;
  assign wr_cfg    = '{en: cfg_en, gt: cfg_gt, chan: cfg_chan, limit: cfg_limit};

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    thr_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (cfg_we && (cfg_idx == IDX_W'(k))),
      .cfg_i  (wr_cfg),
      .valid_i(take),
      .tag_i  (smp_tag),
      .value_i(smp_value),
      .hit_o  (hit[k])
    );
  end

  bat_window #(.BAT_TAG(BAT_TAG)) u_bat (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (bat_we),
    .hi_i   (bat_hi),
    .lo_i   (bat_lo),
    .valid_i(take),
    .tag_i  (smp_tag),
    .value_i(smp_value),
    .hit_o  (hit[N_SLOT])
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~sts_clr) | hit;
  end

  assign irq = |(sts & irq_mask);

  for (genvar b = 0; b < N_STS; b++) begin : g_chk
    // R7
    sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[b] && !sts_clr[b]) |=> sts[b]);
    // R10
    sts_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[b]) |-> $past(smp_valid));
  end

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|sts));
endmodule

// File: tb/chan_thresh_bank_bench.sv
module chan_thresh_bank_bench;
  localparam int NS = 8;
  localparam int NT = NS + 1;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        smp_valid = 0, smp_ready;
  logic [3:0]  smp_tag = 0;
  logic [11:0] smp_value = 0;
  logic        cfg_we = 0, cfg_en = 0, cfg_gt = 0;
  logic [2:0]  cfg_idx = 0;
  logic [3:0]  cfg_chan = 0;
  logic [11:0] cfg_limit = 0;
  logic        bat_we = 0;
  logic [11:0] bat_hi = 0, bat_lo = 0;
  logic [NT-1:0] sts_clr = 0, irq_mask = 0, sts;
  logic        irq;

  always #4 clk = ~clk;

  chan_thresh_bank u_chan_thresh_bank (.*);

  int n_chk = 0, n_bad = 0;
  logic        m_en[NS], m_gt[NS];
  logic [3:0]  m_ch[NS];
  logic [11:0] m_lim[NS];
  logic [11:0] m_hi = 12'hFFF, m_lo = 0;
  logic [NT-1:0] m_sts = 0;

  function automatic logic [NT-1:0] hits(logic v, logic [3:0] t, logic [11:0] x);
    logic [NT-1:0] h = '0;
    if (!v) return h;
    for (int i = 0; i < NS; i++)
      if (m_en[i] && m_ch[i] == t && (m_gt[i] ? (x > m_lim[i]) : (x < m_lim[i]))) h[i] = 1;
    if (t == 4'd8 && (x > m_hi || x < m_lo)) h[NS] = 1;
    return h;
  endfunction

  task automatic check(string req);
    n_chk++;
    if (sts !== m_sts) begin
      n_bad++;
      $display("FAIL %s sts actual=%h expected=%h", req, sts, m_sts);
    end
    n_chk++;
    if (irq !== |(m_sts & irq_mask)) begin
      n_bad++;
      $display("FAIL R9 (%s) irq actual=%b expected=%b", req, irq, |(m_sts & irq_mask));
    end
  endtask

  task automatic step(logic v, logic [3:0] t, logic [11:0] x, logic [NT-1:0] c, string req);
    @(negedge clk);
    smp_valid = v; smp_tag = t; smp_value = x; sts_clr = c;
    m_sts = (m_sts & ~c) | hits(v, t, x);
    @(negedge clk);
    smp_valid = 0; sts_clr = 0;
    check(req);
  endtask

  task automatic wr_slot(int i, logic e, logic g, logic [3:0] ch, logic [11:0] l);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(i); cfg_en = e; cfg_gt = g; cfg_chan = ch; cfg_limit = l;
    m_en[i] = e; m_gt[i] = g; m_ch[i] = ch; m_lim[i] = l;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin m_en[i] = 0; m_gt[i] = 0; m_ch[i] = 0; m_lim[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    irq_mask = '1;
    check("R1");
    n_chk++;
    if (smp_ready !== 1'b1) begin n_bad++; $display("FAIL R10 ready actual=%b expected=1", smp_ready); end
    // R1: reset battery limits never trip, no slot enabled
    step(1, 4'd8, 12'd0, '0, "R1");
    step(1, 4'd8, 12'hFFF, '0, "R1");
    step(1, 4'd0, 12'd0, '0, "R1");

    for (int i = 0; i < NS; i++)
      wr_slot(i, i != 5, i[0], (i < 6) ? 4'(i) : 4'd3, 12'(300 + 450 * i));
    @(negedge clk);
    bat_we = 1; bat_hi = 12'd3000; bat_lo = 12'd500; m_hi = 12'd3000; m_lo = 12'd500;
    @(negedge clk);
    bat_we = 0;

    // R5: slot 0 less-than 300
    step(1, 4'd0, 12'd300, '0, "R5");
    step(1, 4'd0, 12'd299, '0, "R5");
    step(0, 4'd0, 12'd0, '1, "R7");
    // R4: slot 1 greater-than 750
    step(1, 4'd1, 12'd750, '0, "R4");
    step(1, 4'd1, 12'd751, '0, "R4");
    step(0, 4'd0, 12'd0, '0, "R7");
    step(0, 4'd0, 12'd0, '1, "R7");
    // R3: tag 2 value high must not touch slot 1
    step(1, 4'd2, 12'd4095, '0, "R3");
    // R2: slot 5 disabled
    step(1, 4'd5, 12'd0, '0, "R2");
    step(1, 4'd5, 12'd4095, '0, "R2");
    // R8: battery window
    step(1, 4'd8, 12'd3000, '0, "R8");
    step(1, 4'd8, 12'd3001, '0, "R8");
    step(1, 4'd8, 12'd499, '1, "R8");
    step(0, 4'd0, 12'd0, '1, "R7");
    // R10: valid low ignored
    step(0, 4'd0, 12'd0, '0, "R10");
    step(0, 4'd8, 12'd4095, '0, "R10");
    // R6: slots 3, 6, 7 share channel 3
    step(1, 4'd3, 12'd3451, '0, "R6");
    step(1, 4'd3, 12'd2999, '0, "R6");
    // R7: set wins over clear
    step(1, 4'd3, 12'd3451, '1, "R7");
    step(0, 4'd0, 12'd0, '1, "R7");

    irq_mask = 9'h1A5;
    for (int t = 0; t < 16; t++) begin
      for (int j = 0; j < 48; j++) begin
        int x;
        if (j < 16)      x = j * 273;
        else if (j < 40) x = 300 + 450 * ((j - 16) / 3) + ((j - 16) % 3) - 1;
        else if (j < 46) x = ((j < 43) ? 500 : 3000) + ((j - 40) % 3) - 1;
        else             x = (j == 46) ? 0 : 4095;
        step(1, 4'(t), 12'(x), (j % 5 == 0) ? '1 : '0, "R6");
        if (j % 7 != 0) step(0, 4'd0, 12'd0, '1, "R7");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule